// File: doc/BRIEF.md
# BCH Error-Location Bit Corrector

This block takes the result of a finished BCH decode and applies it to a data buffer held in an internal byte RAM of up to 1024 bytes. A one-cycle start pulse carries the decoder's 32-bit status word and a packed vector of error-index words. The block reads the error count and the skip flags from the status word. For every reported position it then performs a read-modify-write on the RAM that inverts exactly one bit.

A host port loads the buffer before a correction and reads it back afterwards. While a correction runs, the host port applies back-pressure. When the run ends, the block pulses `done` and holds a result code until the next run completes. A sticky flag reports positions that fell beyond the configured data length and were therefore skipped. Computing the error positions is not part of this block.

Top module: `bch_bitfix`

## Requirements
- R1: The host port accepts a request on a clock edge where `host_valid` and `host_ready` are both high. With `host_we`=1 the request writes `host_wdata` to byte `host_addr`. With `host_we`=0, `host_rvalid` is high and `host_rdata` holds that byte after the next edge. `host_ready` is low exactly while `busy` is high, and requests offered then have no effect.
- R2: The error count is status bits 31:28. Error k (counting from 0) takes its 13-bit position from index word k/2: even k uses bits 12:0 and odd k uses bits 28:16. Word j occupies bits 32*j+31 down to 32*j of `err_words`.
- R3: A position p selects byte p>>3 and bit p&7, where bit 0 is the least significant bit. Correcting it inverts that bit and leaves the other seven bits unchanged. Corrections are applied in order, so a position reported twice leaves its bit unchanged.
- R4: If status bit 1 (uncorrectable) is set and neither bit 4 nor bit 5 is set, no byte changes and the result code is 2 (uncorrectable).
- R5: If status bit 4 (all-ones block) or bit 5 (all-zeros block) is set, no byte changes and the result code is 0 (clean). This takes priority over bit 1.
- R6: If the count is zero and bits 1, 4 and 5 are all clear, or if any skip case of R4/R5 applies, `done` is high after the second clock edge counting the one that accepts start.
- R7: Each in-range correction takes two cycles (read, then write). `busy` rises at the accepting edge and falls at the edge of the last write. At that same edge `done` rises for exactly one cycle. A run with a nonzero count and no flags reports result code 1 (corrected).
- R8: A position whose byte index is not below `data_len` (sampled at start) is skipped in one cycle and changes no byte. It sets `oor_flag`, which stays set until the next accepted start clears it.
- R9: A start pulse while `busy` is high is ignored: the running correction, its timing and its result are unaffected.
- R10: The result code stays constant between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin applying a decode result (accepted when idle) |
| status | input | 32 | Decoder status word: count in 31:28, flags in bits 5, 4, 1 |
| err_words | input | 256 | Eight packed index words, two 13-bit positions each |
| data_len | input | 11 | Number of valid data bytes in the buffer |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request can be accepted |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 8 | Host read data |
| busy | output | 1 | Correction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| oor_flag | output | 1 | Sticky: a position was beyond `data_len` |

## Verification
The bench drives inputs on falling edges and samples on falling edges. Host read data is checked at the first falling edge after the accepting edge. For a correction, the bench computes the due cycle L from the stimulus: one cycle for any skip case, otherwise two per in-range position plus one per out-of-range position. It then checks `busy` high and `done` low at each of the L falling edges after start, and `done`, `busy` low and the result code at falling edge L. Buffer contents are compared byte by byte against a bench model after each run.

// File: rtl/bch_bitfix_pkg.sv
package bch_bitfix_pkg;
  localparam int POS_W    = 13;
  localparam int CNT_W    = 4;
  localparam int CNT_LSB  = 28;
  localparam int HI_LSB   = 16;
  localparam int ST_UNCOR = 1;
  localparam int ST_ALLF  = 4;
  localparam int ST_ALL0  = 5;

  typedef enum logic [1:0] {
    RES_CLEAN = 2'd0,
    RES_FIXED = 2'd1,
    RES_UNCOR = 2'd2
  } res_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD,
    S_WR,
    S_FIN
  } fix_state_e;
endpackage

// File: rtl/bch_bitfix_unpack.sv
module bch_bitfix_unpack
  import bch_bitfix_pkg::*;
#(
  parameter int IDX_WORDS = 8
) (
  input  logic [IDX_WORDS*32-1:0] words,
  input  logic [CNT_W-1:0]        idx,
  output logic [POS_W-1:0]        pos
);
  localparam int NPOS = 2 * IDX_WORDS;

  logic [POS_W-1:0] pos_arr [NPOS];

  // even slot: low half of word, odd slot: high half
  generate
    for (genvar g = 0; g < NPOS; g++) begin : g_slot
      assign pos_arr[g] = words[(g/2)*32 + (g%2)*HI_LSB +: POS_W];
    end
  endgenerate

  assign pos = pos_arr[idx];
endmodule

// File: rtl/bch_bitfix_ram.sv
module bch_bitfix_ram #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bch_bitfix_ctrl.sv
module bch_bitfix_ctrl
  import bch_bitfix_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int IDX_WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [31:0]             status,
  input  logic [IDX_WORDS*32-1:0] err_words,
  input  logic [ADDR_W:0]         data_len,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              result,
  output logic                    oor_flag,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic [7:0]              ram_wdata,
  input  logic [7:0]              ram_rdata
);
  localparam int BYTE_W = POS_W - 3;
  localparam int CMP_W  = ((BYTE_W > ADDR_W) ? BYTE_W : ADDR_W) + 1;

  fix_state_e               st_q;
  logic [IDX_WORDS*32-1:0]  words_q;
  logic [ADDR_W:0]          len_q;
  logic [CNT_W-1:0]         cnt_q, idx_q;
  res_e                     pend_q, res_q;
  logic                     done_q, oor_q;

  logic [POS_W-1:0]  pos;
  logic [BYTE_W-1:0] byte_w;
  logic [2:0]        bit_s;
  logic              in_range, last;
  logic [CNT_W:0]    idx_nxt;

  bch_bitfix_unpack #(.IDX_WORDS(IDX_WORDS)) u_unpack (
    .words (words_q),
    .idx   (idx_q),
    .pos   (pos)
  );

  assign byte_w   = pos[POS_W-1:3];
  assign bit_s    = pos[2:0];
  assign in_range = CMP_W'(byte_w) < CMP_W'(len_q);
  assign idx_nxt  = {1'b0, idx_q} + 1'b1;
  assign last     = (idx_nxt == {1'b0, cnt_q});

  logic skip_all, flag_uncor;
  assign skip_all   = status[ST_ALLF] | status[ST_ALL0];
  assign flag_uncor = status[ST_UNCOR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      words_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      pend_q  <= RES_CLEAN;
      res_q   <= RES_CLEAN;
      done_q  <= 1'b0;
      oor_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          words_q <= err_words;
          len_q   <= data_len;
          cnt_q   <= status[CNT_LSB +: CNT_W];
          idx_q   <= '0;
          oor_q   <= 1'b0;
          if (skip_all) begin
            pend_q <= RES_CLEAN;
            st_q   <= S_FIN;
          end else if (flag_uncor) begin
            pend_q <= RES_UNCOR;
            st_q   <= S_FIN;
          end else if (status[CNT_LSB +: CNT_W] == '0) begin
            pend_q <= RES_CLEAN;
            st_q   <= S_FIN;
          end else begin
            pend_q <= RES_FIXED;
            st_q   <= S_RD;
          end
        end
        S_RD: begin
          if (in_range) begin
            st_q <= S_WR;
          end else begin
            oor_q <= 1'b1;
            if (last) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
              res_q  <= pend_q;
            end else begin
              idx_q <= idx_nxt[CNT_W-1:0];
            end
          end
        end
        S_WR: begin
          if (last) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            res_q  <= pend_q;
          end else begin
            idx_q <= idx_nxt[CNT_W-1:0];
            st_q  <= S_RD;
          end
        end
        S_FIN: begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
          res_q  <= pend_q;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign result    = res_q;
  assign oor_flag  = oor_q;
  assign ram_we    = (st_q == S_WR);
  assign ram_addr  = ADDR_W'(byte_w);
  assign ram_wdata = ram_rdata ^ (8'd1 << bit_s);
endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix #(
  parameter int DEPTH     = 1024,
  parameter int IDX_WORDS = 8,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [31:0]             status,
  input  logic [IDX_WORDS*32-1:0] err_words,
  input  logic [ADDR_W:0]         data_len,
  input  logic                    host_valid,
  output logic                    host_ready,
  input  logic                    host_we,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [7:0]              host_wdata,
  output logic                    host_rvalid,
  output logic [7:0]              host_rdata,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              result,
  output logic                    oor_flag
);
  logic              c_we;
  logic [ADDR_W-1:0] c_addr;
  logic [7:0]        c_wdata;
  logic              m_we;
  logic [ADDR_W-1:0] m_addr;
  logic [7:0]        m_wdata, m_rdata;
  logic              host_acc;

  bch_bitfix_ctrl #(.ADDR_W(ADDR_W), .IDX_WORDS(IDX_WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .status    (status),
    .err_words (err_words),
    .data_len  (data_len),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .oor_flag  (oor_flag),
    .ram_we    (c_we),
    .ram_addr  (c_addr),
    .ram_wdata (c_wdata),
    .ram_rdata (m_rdata)
  );

  assign host_ready = ~busy;
  assign host_acc   = host_valid & host_ready;
  assign m_we       = busy ? c_we    : (host_acc & host_we);
  assign m_addr     = busy ? c_addr  : host_addr;
  assign m_wdata    = busy ? c_wdata : host_wdata;

  bch_bitfix_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_wdata),
    .rdata (m_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_acc & ~host_we;
  end

  assign host_rdata = m_rdata;
endmodule

// File: rtl/bch_bitfix_chk.sv
module bch_bitfix_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] status,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic        oor_flag,
  input logic        host_ready
);
  logic acc, quick;
  logic cap_allx, cap_uncor;

  assign acc   = start & ~busy;
  assign quick = status[5] | status[4] | status[1] | (status[31:28] == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_allx  <= 1'b0;
      cap_uncor <= 1'b0;
    end else if (acc) begin
      cap_allx  <= status[5] | status[4];
      cap_uncor <= status[1];
    end
  end

  assert_ready_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_ready);

  assert_uncor_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_uncor && !cap_allx) |-> (result == 2'd2));

  assert_allx_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_allx) |-> (result == 2'd0));

  assert_quick_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && quick) |-> ##2 done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_oor_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_flag && !acc) |=> oor_flag);

  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind bch_bitfix bch_bitfix_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .status     (status),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .oor_flag   (oor_flag),
  .host_ready (host_ready)
);

// File: tb/bch_bitfix_test.sv
`timescale 1ns/1ps
module bch_bitfix_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  status = '0;
  logic [255:0] err_words = '0;
  logic [10:0]  data_len = 11'd1024;
  logic         host_valid = 1'b0;
  logic         host_ready;
  logic         host_we = 1'b0;
  logic [9:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic         host_rvalid;
  logic [7:0]   host_rdata;
  logic         busy, done, oor_flag;
  logic [1:0]   result;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [64];

  always #5 clk = ~clk;

  bch_bitfix uut (
    .clk(clk), .rst_n(rst_n), .start(start), .status(status),
    .err_words(err_words), .data_len(data_len),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .busy(busy), .done(done), .result(result), .oor_flag(oor_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] put(input logic [255:0] w, input int k,
                                       input logic [12:0] p);
    logic [255:0] r = w;
    r[(k/2)*32 + (k%2)*16 +: 13] = p;
    return r;
  endfunction

  function automatic logic [31:0] cnt_st(input int n);
    return 32'(n) << 28;
  endfunction

  task automatic host_wr(input int a, input logic [7:0] d);
    host_valid = 1'b1; host_we = 1'b1; host_addr = 10'(a); host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [7:0] d, input string req);
    host_valid = 1'b1; host_we = 1'b0; host_addr = 10'(a);
    @(negedge clk);
    host_valid = 1'b0;
    chk(host_rvalid === 1'b1, req, 32'(host_rvalid), 32'd1);
    d = host_rdata;
  endtask

  task automatic verify(input int lo, input int hi, input string req);
    logic [7:0] d;
    for (int i = lo; i <= hi; i++) begin
      host_rd(i, d, req);
      chk(d === model[i], req, 32'(d), 32'(model[i]));
    end
  endtask

  task automatic flip(input int p);
    model[p >> 3] = model[p >> 3] ^ (8'd1 << (p & 7));
  endtask

  // drive a run; done is due at falling edge lat after the accepting edge
  task automatic run_fix(input logic [31:0] st, input logic [255:0] w,
                         input int len, input int lat, input logic [1:0] exp_res,
                         input string req);
    start = 1'b1; status = st; err_words = w; data_len = 11'(len);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < lat; k++) begin
      chk(busy === 1'b1 && done === 1'b0, req, {busy, done}, 32'b10);
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b0, req, {busy, done}, 32'b01);
    chk(result === exp_res, req, 32'(result), 32'(exp_res));
    @(negedge clk);
    chk(done === 1'b0, {req, " done pulse"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0, "R7 reset", {busy, done}, 32'd0);
    chk(result === 2'd0 && oor_flag === 1'b0, "R10 reset", {result, oor_flag}, 32'd0);
    chk(host_ready === 1'b1, "R1 reset ready", 32'(host_ready), 32'd1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 64; i++) begin
      model[i] = 8'(i * 37 + 5);
      host_wr(i, model[i]);
    end
    verify(0, 63, "R1 fill readback");
  endtask

  task automatic t_three();
    logic [255:0] w = '0;
    w = put(w, 0, 13'd5); w = put(w, 1, 13'd100); w = put(w, 2, 13'd17);
    flip(5); flip(100); flip(17);
    run_fix(cnt_st(3), w, 1024, 6, 2'd1, "R7 R2 three errors");
    verify(0, 15, "R3 three errors data");
  endtask

  task automatic t_same_byte();
    logic [255:0] w = '0;
    w = put(w, 0, 13'd9); w = put(w, 1, 13'd9);
    w = put(w, 2, 13'd10); w = put(w, 3, 13'd11);
    flip(10); flip(11);
    run_fix(cnt_st(4), w, 1024, 8, 2'd1, "R3 same byte");
    verify(0, 3, "R3 same byte data");
  endtask

  task automatic t_eight();
    logic [255:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      w = put(w, k, 13'(k * 40 + k));
      flip(k * 40 + k);
    end
    run_fix(cnt_st(8), w, 1024, 16, 2'd1, "R2 eight errors");
    verify(0, 40, "R2 eight errors data");
  endtask

  task automatic t_uncor();
    logic [255:0] w = '0;
    w = put(w, 0, 13'd1); w = put(w, 1, 13'd2); w = put(w, 2, 13'd3);
    run_fix(cnt_st(3) | 32'h2, w, 1024, 1, 2'd2, "R4 R6 uncorrectable");
    verify(0, 1, "R4 no change");
  endtask

  task automatic t_allx();
    logic [255:0] w = '0;
    w = put(w, 0, 13'd0); w = put(w, 1, 13'd8);
    run_fix(cnt_st(2) | 32'h10, w, 1024, 1, 2'd0, "R5 all ones");
    run_fix(cnt_st(2) | 32'h22, w, 1024, 1, 2'd0, "R5 all zeros over uncor");
    verify(0, 1, "R5 no change");
  endtask

  task automatic t_zero();
    run_fix(32'h0, '0, 1024, 1, 2'd0, "R6 zero count");
    repeat (3) @(negedge clk);
    chk(result === 2'd0, "R10 hold", 32'(result), 32'd0);
  endtask

  task automatic t_oor();
    logic [255:0] w = '0;
    w = put(w, 0, 13'd163); w = put(w, 1, 13'd24);
    flip(24);
    run_fix(cnt_st(2), w, 16, 3, 2'd1, "R8 out of range");
    chk(oor_flag === 1'b1, "R8 flag set", 32'(oor_flag), 32'd1);
    repeat (4) @(negedge clk);
    chk(oor_flag === 1'b1, "R8 flag sticky", 32'(oor_flag), 32'd1);
    chk(result === 2'd1, "R10 hold after oor", 32'(result), 32'd1);
    verify(3, 3, "R8 in range fixed");
    verify(20, 20, "R8 skipped byte");
    run_fix(32'h0, '0, 1024, 1, 2'd0, "R8 next run");
    chk(oor_flag === 1'b0, "R8 flag cleared", 32'(oor_flag), 32'd0);
  endtask

  task automatic t_busy_start();
    logic [255:0] w = '0;
    w = put(w, 0, 13'd320); w = put(w, 1, 13'd335);
    flip(320); flip(335);
    start = 1'b1; status = cnt_st(2); err_words = w; data_len = 11'd1024;
    @(negedge clk);
    chk(host_ready === 1'b0, "R1 ready low while busy", 32'(host_ready), 32'd0);
    start = 1'b1; status = 32'h2;
    host_valid = 1'b1; host_we = 1'b1; host_addr = 10'd40; host_wdata = 8'h00;
    @(negedge clk);
    start = 1'b0; host_valid = 1'b0; host_we = 1'b0;
    for (int k = 1; k < 4; k++) begin
      chk(busy === 1'b1 && done === 1'b0, "R9 busy run", {busy, done}, 32'b10);
      @(negedge clk);
    end
    chk(done === 1'b1 && result === 2'd1, "R9 start ignored", {done, result}, 32'b101);
    @(negedge clk);
    chk(busy === 1'b0, "R9 no restart", 32'(busy), 32'd0);
    verify(40, 41, "R1 R9 blocked write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_three();
    t_same_byte();
    t_eight();
    t_uncor();
    t_allx();
    t_zero();
    t_oor();
    t_busy_start();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule